// File: doc/BRIEF.md
# Acquisition Card Interrupt Controller

This block gathers the interrupt causes of a small data-acquisition card and folds them into one registered request line towards the host. Software programs a write-only 8-bit enable register over a simple bus made of an address, a write strobe and a data byte. Three further write-only addresses acknowledge the latched requests; the data written to them has no effect.

The causes are of three kinds. The converter FIFO-not-empty flag is a level request and follows the flag. The converter overflow and overrun errors and the DMA terminal-count pulse each set a sticky request. A rising edge of the update-counter output, or of the inverted active-low external update strobe, sets one shared sticky request. Both of these inputs are resynchronised before the edge is detected. Two enable bits, one for the digital-I/O interrupt and one for DMA, are only stored and brought out to neighbouring logic.

Top module: `acq_irq_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `irqOut`, `dioIrqEn` and `dmaEn` are 0, and no sticky request is pending.
- R2: A write to offset 0x02 loads the enable register from the data byte. Bit 5 enables the FIFO request, bit 4 the error request, bit 3 the counter/update request and bit 2 the terminal-count request. Bit 1 drives `dioIrqEn` and bit 0 drives `dmaEn`. Bits 7 and 6 are ignored.
- R3: With bit 5 set, `irqOut` is 1 on the cycle after one in which `fifoNotEmpty` is 1. With bit 5 clear, the FIFO flag has no effect.
- R4: With bit 4 set, a cycle in which `adcOverflow` or `adcOverrun` is 1 latches the error request. The request stays after the flags drop and is removed only by a write to offset 0x0A.
- R5: With bit 3 set, a 0-to-1 change of `updCounterOut`, or a 1-to-0 change of `extUpdateN`, latches the counter request after two synchroniser stages. The request is removed by a write to offset 0x0C.
- R6: With bit 3 clear, edges on `updCounterOut` and `extUpdateN` latch nothing, so setting bit 3 afterwards raises no request.
- R7: With bit 2 set, a cycle in which `dmaTcPulse` is 1 latches the terminal-count request, and `irqOut` rises two clock edges after that cycle. The request is removed by a write to offset 0x0E.
- R8: When a clear write and a new set event for the same request fall in one cycle, the request stays latched.
- R9: `irqOut` is the registered OR of every pending request ANDed with its enable bit. Clearing an enable bit masks a latched request without discarding it, and each clear address removes only its own request. Writes to the clear addresses leave the enable register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 4 | Register offset of the write |
| busWe | input | 1 | Write strobe, one cycle per write |
| busData | input | 8 | Write data |
| fifoNotEmpty | input | 1 | Converter FIFO holds at least one result |
| adcOverflow | input | 1 | Converter overflow error flag |
| adcOverrun | input | 1 | Converter overrun error flag |
| updCounterOut | input | 1 | Update-counter output, asynchronous |
| extUpdateN | input | 1 | External update strobe, active low, asynchronous |
| dmaTcPulse | input | 1 | DMA terminal-count pulse, synchronous |
| irqOut | output | 1 | Interrupt request to the host |
| dioIrqEn | output | 1 | Stored digital-I/O interrupt enable |
| dmaEn | output | 1 | Stored DMA enable |

## Verification
Every internal fault reaches `irqOut` within a few cycles. A sticky request that is lost or cleared wrongly shows as a low line two edges after its set event, or after the matching clear write. A request latched while its enable was clear only becomes visible once that enable is written, so the bench sets the enable afterwards and watches `irqOut` stay low. A corrupted enable register shows at once on `dioIrqEn` and `dmaEn`, and through the masking of requests that are known to be pending.

// File: rtl/acq_irq_pkg.sv
package acq_irq_pkg;

  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int SYNC_STAGES = 2;
  localparam int NUM_EDGE_SRC = 2;

  // register offsets; the values are the block's contract
  localparam int OFS_ENABLE    = 'h2;
  localparam int OFS_CLR_ADC   = 'hA;
  localparam int OFS_CLR_TIMER = 'hC;
  localparam int OFS_CLR_TC    = 'hE;

  // enable register bit positions
  localparam int EN_W    = 6;
  localparam int EN_FIFO = 5;
  localparam int EN_ERR  = 4;
  localparam int EN_CNT  = 3;
  localparam int EN_TC   = 2;
  localparam int EN_DIO  = 1;
  localparam int EN_DMA  = 0;

  // sticky request slots
  localparam int NUM_STICKY = 3;
  localparam int SRC_ERR = 0;
  localparam int SRC_CNT = 1;
  localparam int SRC_TC  = 2;

  typedef struct packed {
    logic loadEnable;
    logic clrAdc;
    logic clrTimer;
    logic clrTc;
  } ctrlStrb_t;

endpackage

// File: rtl/acq_irq_sync.sv
module acq_irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/acq_irq_decode.sv
module acq_irq_decode
  import acq_irq_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          busWe,
  input  logic [AW-1:0] busAddr,
  output ctrlStrb_t     strb
);

  always_comb begin
    strb = '0;
    if (busWe) begin
      strb.loadEnable = (busAddr == AW'(OFS_ENABLE));
      strb.clrAdc     = (busAddr == AW'(OFS_CLR_ADC));
      strb.clrTimer   = (busAddr == AW'(OFS_CLR_TIMER));
      strb.clrTc      = (busAddr == AW'(OFS_CLR_TC));
    end
  end

endmodule

// File: rtl/acq_irq_datapath.sv
module acq_irq_datapath
  import acq_irq_pkg::*;
#(
  parameter int NSYNC = SYNC_STAGES,
  parameter int NEDGE = NUM_EDGE_SRC
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic [EN_W-1:0]  enData,
  input  logic             fifoNotEmpty,
  input  logic             adcOverflow,
  input  logic             adcOverrun,
  input  logic [NEDGE-1:0] edgeSrc,
  input  logic             dmaTcPulse,
  output logic             irqOut,
  output logic             dioIrqEn,
  output logic             dmaEn
);

  logic [EN_W-1:0]       enReg;
  logic [NEDGE-1:0]      edgeSync;
  logic                  cntLevel;
  logic                  cntPrev;
  logic                  cntRise;
  logic [NUM_STICKY-1:0] pendSet;
  logic [NUM_STICKY-1:0] pendClr;
  logic [NUM_STICKY-1:0] pendEn;
  logic [NUM_STICKY-1:0] pend;
  logic                  irqNext;
  logic                  irqReg;

  // enable register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               enReg <= '0;
    else if (strb.loadEnable) enReg <= enData;
  end

  // resynchronise every asynchronous edge source
  generate
    for (genvar e = 0; e < NEDGE; e++) begin : g_edge_sync
      acq_irq_sync #(.STAGES(NSYNC)) u_sync (
        .clk  (clk),
        .rstN (rstN),
        .d    (edgeSrc[e]),
        .q    (edgeSync[e])
      );
    end
  endgenerate

  // combined edge source, rising-edge detection
  assign cntLevel = |edgeSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cntPrev <= 1'b0;
    else       cntPrev <= cntLevel;
  end

  assign cntRise = cntLevel & ~cntPrev;

  // set, clear and enable per sticky slot
  always_comb begin
    pendSet[SRC_ERR] = enReg[EN_ERR] & (adcOverflow | adcOverrun);
    pendSet[SRC_CNT] = enReg[EN_CNT] & cntRise;
    pendSet[SRC_TC]  = enReg[EN_TC]  & dmaTcPulse;
    pendClr[SRC_ERR] = strb.clrAdc;
    pendClr[SRC_CNT] = strb.clrTimer;
    pendClr[SRC_TC]  = strb.clrTc;
    pendEn[SRC_ERR]  = enReg[EN_ERR];
    pendEn[SRC_CNT]  = enReg[EN_CNT];
    pendEn[SRC_TC]   = enReg[EN_TC];
  end

  // a set event in the same cycle as a clear wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend <= '0;
    end else begin
      for (int s = 0; s < NUM_STICKY; s++) begin
        pend[s] <= pendSet[s] | (pend[s] & ~pendClr[s]);
      end
    end
  end

  // request output
  assign irqNext = (enReg[EN_FIFO] & fifoNotEmpty) | (|(pend & pendEn));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqReg <= 1'b0;
    else       irqReg <= irqNext;
  end

  assign irqOut   = irqReg;
  assign dioIrqEn = enReg[EN_DIO];
  assign dmaEn    = enReg[EN_DMA];

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rstN |=> !irqOut);

  // R3
  fifo_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enReg[EN_FIFO] && fifoNotEmpty) |=> irqOut);

  // R4
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pend[SRC_ERR] && !strb.clrAdc) |=> pend[SRC_ERR]);

  // R6
  cnt_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!enReg[EN_CNT] && !pend[SRC_CNT]) |=> !pend[SRC_CNT]);

  // R8
  tc_set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrTc && enReg[EN_TC] && dmaTcPulse) |=> pend[SRC_TC]);

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoNotEmpty && ((pend & pendEn) == '0)) |=> !irqOut);

endmodule

// File: rtl/acq_irq_ctrl.sv
module acq_irq_ctrl
  import acq_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busData,
  input  logic              fifoNotEmpty,
  input  logic              adcOverflow,
  input  logic              adcOverrun,
  input  logic              updCounterOut,
  input  logic              extUpdateN,
  input  logic              dmaTcPulse,
  output logic              irqOut,
  output logic              dioIrqEn,
  output logic              dmaEn
);

  ctrlStrb_t               strb;
  logic [NUM_EDGE_SRC-1:0] edgeSrc;
  logic                    unusedHighBits;

  // bits above the enable field carry no function
  assign unusedHighBits = ^busData[DATA_W-1:EN_W];

  assign edgeSrc = {~extUpdateN, updCounterOut};

  acq_irq_decode #(.AW(ADDR_W)) u_decode (
    .busWe   (busWe),
    .busAddr (busAddr),
    .strb    (strb)
  );

  acq_irq_datapath #(
    .NSYNC (SYNC_STAGES),
    .NEDGE (NUM_EDGE_SRC)
  ) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .enData       (busData[EN_W-1:0]),
    .fifoNotEmpty (fifoNotEmpty),
    .adcOverflow  (adcOverflow),
    .adcOverrun   (adcOverrun),
    .edgeSrc      (edgeSrc),
    .dmaTcPulse   (dmaTcPulse),
    .irqOut       (irqOut),
    .dioIrqEn     (dioIrqEn),
    .dmaEn        (dmaEn)
  );

endmodule

// File: tb/acq_irq_ctrl_bench.sv
`timescale 1ns/1ps
module acq_irq_ctrl_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] busAddr = '0;
  logic       busWe = 1'b0;
  logic [7:0] busData = '0;
  logic       fifoNotEmpty = 1'b0;
  logic       adcOverflow = 1'b0;
  logic       adcOverrun = 1'b0;
  logic       updCounterOut = 1'b0;
  logic       extUpdateN = 1'b1;
  logic       dmaTcPulse = 1'b0;
  logic       irqOut;
  logic       dioIrqEn;
  logic       dmaEn;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  acq_irq_ctrl u_acq_irq_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busData(busData),
    .fifoNotEmpty(fifoNotEmpty), .adcOverflow(adcOverflow), .adcOverrun(adcOverrun),
    .updCounterOut(updCounterOut), .extUpdateN(extUpdateN), .dmaTcPulse(dmaTcPulse),
    .irqOut(irqOut), .dioIrqEn(dioIrqEn), .dmaEn(dmaEn)
  );

  // [15:8] enable byte, [7] fifo, [6] overflow, [5] overrun,
  // [4] counter edge, [3] external strobe edge, [2] tc pulse, [1] expected irq
  localparam int NVEC = 12;
  localparam logic [15:0] VEC [NVEC] = '{
    16'h2082, 16'h0080, 16'h1042, 16'h1022, 16'h0812, 16'h080A,
    16'h0406, 16'h1B04, 16'hC080, 16'h3F00, 16'h2F40, 16'h0410
  };

  task automatic waitCyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busData = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic clearAll();
    fifoNotEmpty = 1'b0; adcOverflow = 1'b0; adcOverrun = 1'b0;
    busWrite(4'hA, 8'h00);
    busWrite(4'hC, 8'h00);
    busWrite(4'hE, 8'h00);
    busWrite(4'h2, 8'h00);
    waitCyc(3);
  endtask

  task automatic tcPulse();
    @(negedge clk); dmaTcPulse = 1'b1;
    @(negedge clk); dmaTcPulse = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    waitCyc(3);
    // R1 reset state
    check("R1 irq in reset", {7'b0, irqOut}, 8'h0);
    check("R1 enables in reset", {6'b0, dioIrqEn, dmaEn}, 8'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 irq after reset", {7'b0, irqOut}, 8'h0);
    check("R1 enables after reset", {6'b0, dioIrqEn, dmaEn}, 8'h0);

    // R2 R3 R4 R5 R7 vector table
    for (int i = 0; i < NVEC; i++) begin
      v = VEC[i];
      busWrite(4'h2, v[15:8]);
      fifoNotEmpty = v[7]; adcOverflow = v[6]; adcOverrun = v[5];
      if (v[4]) updCounterOut = 1'b1;
      if (v[3]) extUpdateN = 1'b0;
      if (v[2]) dmaTcPulse = 1'b1;
      @(negedge clk);
      dmaTcPulse = 1'b0;
      adcOverflow = 1'b0; adcOverrun = 1'b0;
      waitCyc(3);
      updCounterOut = 1'b0; extUpdateN = 1'b1;
      waitCyc(3);
      check($sformatf("R2 vector %0d irq", i), {7'b0, irqOut}, {7'b0, v[1]});
      check($sformatf("R2 vector %0d exported bits", i), {6'b0, dioIrqEn, dmaEn}, {6'b0, v[9:8]});
      clearAll();
    end

    // R7 latency: irq rises two edges after the pulse cycle
    busWrite(4'h2, 8'h04);
    tcPulse();
    check("R7 irq one edge after pulse", {7'b0, irqOut}, 8'h0);
    @(negedge clk);
    check("R7 irq two edges after pulse", {7'b0, irqOut}, 8'h1);
    busWrite(4'hE, 8'h00);
    @(negedge clk);
    check("R7 cleared by 0x0E", {7'b0, irqOut}, 8'h0);

    // R8 set wins over simultaneous clear
    @(negedge clk);
    busAddr = 4'hE; busWe = 1'b1; dmaTcPulse = 1'b1;
    @(negedge clk);
    busWe = 1'b0; dmaTcPulse = 1'b0;
    waitCyc(2);
    check("R8 set wins over clear", {7'b0, irqOut}, 8'h1);
    clearAll();

    // R6 edges ignored while disabled
    updCounterOut = 1'b1; waitCyc(4); updCounterOut = 1'b0;
    extUpdateN = 1'b0; waitCyc(4); extUpdateN = 1'b1;
    waitCyc(4);
    busWrite(4'h2, 8'h08);
    waitCyc(4);
    check("R6 disabled edges latched nothing", {7'b0, irqOut}, 8'h0);

    // R5 latch then clear via 0x0C
    extUpdateN = 1'b0; waitCyc(6); extUpdateN = 1'b1;
    check("R5 strobe edge raises irq", {7'b0, irqOut}, 8'h1);
    busWrite(4'hC, 8'hFF);
    waitCyc(2);
    check("R5 cleared by 0x0C", {7'b0, irqOut}, 8'h0);
    clearAll();

    // R4 sticky error and R9 clear isolation
    busWrite(4'h2, 8'h14);
    @(negedge clk); adcOverrun = 1'b1;
    @(negedge clk); adcOverrun = 1'b0;
    tcPulse();
    waitCyc(3);
    check("R4 error sticky after flag drops", {7'b0, irqOut}, 8'h1);
    busWrite(4'hA, 8'h00);
    waitCyc(2);
    check("R9 0x0A leaves tc request", {7'b0, irqOut}, 8'h1);
    busWrite(4'h2, 8'h10);
    waitCyc(2);
    check("R9 enable clear masks tc", {7'b0, irqOut}, 8'h0);
    busWrite(4'h2, 8'h04);
    waitCyc(2);
    check("R9 tc request kept while masked", {7'b0, irqOut}, 8'h1);
    busWrite(4'hE, 8'h00);
    waitCyc(2);
    check("R9 0x0E removes tc, error gone", {7'b0, irqOut}, 8'h0);

    // R9 data on clear address ignored, R2 high bits ignored
    busWrite(4'h2, 8'hC1);
    busWrite(4'hA, 8'h3E);
    busWrite(4'hC, 8'h3E);
    busWrite(4'hE, 8'h3E);
    check("R9 clear writes keep enables", {6'b0, dioIrqEn, dmaEn}, 8'h1);
    fifoNotEmpty = 1'b1;
    waitCyc(2);
    check("R3 fifo ignored when bit 5 clear", {7'b0, irqOut}, 8'h0);
    busWrite(4'h2, 8'h22);
    check("R2 dio bit exported", {6'b0, dioIrqEn, dmaEn}, 8'h2);
    @(negedge clk);
    check("R3 fifo level raises irq", {7'b0, irqOut}, 8'h1);
    fifoNotEmpty = 1'b0;
    waitCyc(2);
    check("R3 irq follows fifo empty", {7'b0, irqOut}, 8'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule